// File: doc/BRIEF.md
# Memory-Mapped Character Terminal Controller

This block is a bus slave that gives a processor four word-spaced device registers for driving a character terminal. The receive side takes bytes from a keyboard-facing strobe and holds the most recent one in a data register. A ready flag marks that byte as not yet read. The transmit side accepts a byte written by the processor and hands it to a display-facing output port. After each accepted byte the transmit side stays busy until a set number of instruction-retire ticks has been counted.

The two sides are fully independent. A received byte is never echoed to the display. Each ready flag changes only as a side effect of data events, and software controls only the interrupt enable bits. Each side drives its own level interrupt request. That request is high while its enable is set and its ready flag is 1. A byte written while the transmitter is busy is accepted on the bus and then discarded.

Reads are combinational in the cycle `bus_re` is high. Side effects of a read or write take effect at the next clock edge.

Top module: `term_mmio`

## Requirements
- R1: After reset the receive ready flag is 0, the transmit ready flag is 1, both interrupt enables are 0, both interrupt outputs are low and `rx_overrun` is 0.
- R2: Byte offsets decode as follows: 0x0 is receive control, 0x4 is receive data, 0x8 is transmit control and 0xC is transmit data. In each control register, bit 0 is the ready flag and bit 1 is the interrupt enable, and bits 31:2 read as 0. Reads of 0xC, of offsets at or above 0x10 and of offsets not a multiple of 4 return 0.
- R3: A `kb_valid` pulse stores `kb_byte`, and the receive ready flag is 1 from the next cycle. Offset 0x4 reads that byte in bits 7:0, with 0 in bits 31:8. The stored byte changes only on `kb_valid`.
- R4: A read of offset 0x4 clears the receive ready flag at the next edge. Writes to offset 0x4 have no effect.
- R5: A write to a control register sets its interrupt enable from `bus_wdata[1]`. Its ready bit is not changed by the write.
- R6: `irq_rx` equals receive enable AND receive ready, and `irq_tx` equals transmit enable AND transmit ready.
- R7: A write to offset 0xC while transmit ready is 1 drives `disp_valid` high for that one cycle, with `disp_byte` equal to `bus_wdata[7:0]`. Transmit ready reads 0 from the next cycle.
- R8: Once busy, the transmitter returns to ready at the edge that samples the BUSY_TICKS-th `instr_tick` pulse. Clock cycles without `instr_tick` do not advance the count.
- R9: A write to offset 0xC while transmit ready is 0 gives no `disp_valid` and does not restart the busy count.
- R10: A byte that arrives while receive ready is 1 overwrites the data register and sets `rx_overrun`, which stays set until a read of 0x4. If a byte arrives in the same cycle as a read of 0x4, the read returns the old byte, and afterwards ready is 1, `rx_overrun` is 0 and the data register holds the new byte.
- R11: A received byte never produces `disp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte offset into the block |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid while bus_re is high |
| kb_valid | input | 1 | One-cycle strobe: a new character is present |
| kb_byte | input | CHAR_W | Incoming character |
| instr_tick | input | 1 | One pulse per retired instruction |
| disp_valid | output | 1 | One-cycle strobe: disp_byte is to be displayed |
| disp_byte | output | CHAR_W | Outgoing character |
| irq_rx | output | 1 | Level interrupt request 0 (receive) |
| irq_tx | output | 1 | Level interrupt request 1 (transmit) |
| rx_overrun | output | 1 | Sticky flag: an unread character was overwritten |

## Verification
The hardest case to reach from the ports is a character that arrives in the same cycle as a read of the receive data register. The bench drives `kb_valid` and the read strobe in one cycle, samples the old byte on the bus, and then reads back ready, overrun and the new byte. The second hard case is a write to the transmit data register while the transmitter is busy. The bench issues one, then idles with no ticks, and then gives exactly the tick count. This shows that the dropped write neither restarted nor extended the busy window.

// File: rtl/term_mmio_pkg.sv
package term_mmio_pkg;
  localparam int OFS_RX_CTRL = 4'h0;
  localparam int OFS_RX_DATA = 4'h4;
  localparam int OFS_TX_CTRL = 4'h8;
  localparam int OFS_TX_DATA = 4'hC;
  localparam int SPAN_BITS   = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RX_CTRL,
    SEL_RX_DATA,
    SEL_TX_CTRL,
    SEL_TX_DATA
  } reg_sel_e;
endpackage

// File: rtl/term_bus_dec.sv
module term_bus_dec
  import term_mmio_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam int HI_W = ADDR_W - SPAN_BITS;

  logic in_span;

  generate
    if (HI_W > 0) begin : g_hi
      assign in_span = (addr[ADDR_W-1:SPAN_BITS] == '0);
    end else begin : g_nohi
      assign in_span = 1'b1;
    end
  endgenerate

  always_comb begin
    sel = SEL_NONE;
    if (in_span && addr[1:0] == 2'b00) begin
      case (addr[SPAN_BITS-1:2])
        2'd0:    sel = SEL_RX_CTRL;
        2'd1:    sel = SEL_RX_DATA;
        2'd2:    sel = SEL_TX_CTRL;
        default: sel = SEL_TX_DATA;
      endcase
    end
  end
endmodule

// File: rtl/term_rx_unit.sv
module term_rx_unit #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kb_valid,
  input  logic [CHAR_W-1:0] kb_byte,
  input  logic              ctrl_we,
  input  logic              ien_wr,
  input  logic              data_rd,
  output logic              ready,
  output logic [CHAR_W-1:0] data,
  output logic              ien,
  output logic              overrun
);
  logic              ready_n, ien_n, ovr_n;
  logic [CHAR_W-1:0] data_n;

  always_comb begin
    ready_n = ready;
    data_n  = data;
    ien_n   = ien;
    ovr_n   = overrun;
    if (ctrl_we) ien_n = ien_wr;
    if (data_rd) begin
      ready_n = 1'b0;
      ovr_n   = 1'b0;
    end
    if (kb_valid) begin
      data_n  = kb_byte;
      ready_n = 1'b1;
      if (ready && !data_rd) ovr_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready   <= 1'b0;
      data    <= '0;
      ien     <= 1'b0;
      overrun <= 1'b0;
    end else begin
      ready   <= ready_n;
      ien     <= ien_n;
      overrun <= ovr_n;
      if (kb_valid) data <= data_n;
    end
  end
endmodule

// File: rtl/term_tx_unit.sv
module term_tx_unit #(
  parameter int CHAR_W     = 8,
  parameter int BUSY_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_we,
  input  logic [CHAR_W-1:0] wbyte,
  input  logic              tick,
  input  logic              ctrl_we,
  input  logic              ien_wr,
  output logic              ready,
  output logic              ien,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_byte
);
  localparam int CNT_W = (BUSY_TICKS < 2) ? 1 : $clog2(BUSY_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_TICKS);

  logic             accept;
  logic             ready_n, ien_n;
  logic [CNT_W-1:0] cnt, cnt_n;

  assign accept    = data_we && ready;
  assign out_valid = accept;
  assign out_byte  = wbyte;

  always_comb begin
    ready_n = ready;
    cnt_n   = cnt;
    ien_n   = ien;
    if (ctrl_we) ien_n = ien_wr;
    if (accept) begin
      ready_n = 1'b0;
      cnt_n   = CNT_LOAD;
    end else if (!ready && tick) begin
      if (cnt <= CNT_W'(1)) begin
        ready_n = 1'b1;
        cnt_n   = '0;
      end else begin
        cnt_n = cnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b1;
      cnt   <= '0;
      ien   <= 1'b0;
    end else begin
      ready <= ready_n;
      cnt   <= cnt_n;
      ien   <= ien_n;
    end
  end
endmodule

// File: rtl/term_mmio.sv
module term_mmio
  import term_mmio_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int CHAR_W     = 8,
  parameter int BUSY_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kb_valid,
  input  logic [CHAR_W-1:0] kb_byte,
  input  logic              instr_tick,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_byte,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              rx_overrun
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  reg_sel_e sel;
  term_bus_dec #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .sel(sel));

  logic              rx_rdy, rx_ien, tx_rdy, tx_ien;
  logic [CHAR_W-1:0] rx_byte_q;

  term_rx_unit #(.CHAR_W(CHAR_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .kb_valid(kb_valid),
    .kb_byte (kb_byte),
    .ctrl_we (bus_we && sel == SEL_RX_CTRL),
    .ien_wr  (bus_wdata[1]),
    .data_rd (bus_re && sel == SEL_RX_DATA),
    .ready   (rx_rdy),
    .data    (rx_byte_q),
    .ien     (rx_ien),
    .overrun (rx_overrun)
  );

  term_tx_unit #(.CHAR_W(CHAR_W), .BUSY_TICKS(BUSY_TICKS)) u_tx (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .data_we  (bus_we && sel == SEL_TX_DATA),
    .wbyte    (bus_wdata[CHAR_W-1:0]),
    .tick     (instr_tick),
    .ctrl_we  (bus_we && sel == SEL_TX_CTRL),
    .ien_wr   (bus_wdata[1]),
    .ready    (tx_rdy),
    .ien      (tx_ien),
    .out_valid(disp_valid),
    .out_byte (disp_byte)
  );

  assign irq_rx = rx_ien && rx_rdy;
  assign irq_tx = tx_ien && tx_rdy;

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      case (sel)
        SEL_RX_CTRL: bus_rdata = DATA_W'({rx_ien, rx_rdy});
        SEL_RX_DATA: bus_rdata = DATA_W'(rx_byte_q);
        SEL_TX_CTRL: bus_rdata = DATA_W'({tx_ien, tx_rdy});
        default:     bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/term_mmio_chk.sv
module term_mmio_chk #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              kb_valid,
  input logic              rx_ready,
  input logic [CHAR_W-1:0] rx_data,
  input logic              rx_overrun,
  input logic              disp_valid,
  input logic              tx_ready,
  input logic              instr_tick,
  input logic              irq_rx
);
  assert_rx_ready_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kb_valid |=> rx_ready);

  assert_rx_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !kb_valid |=> $stable(rx_data));

  assert_irq_needs_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> rx_ready);

  assert_tx_busy_after_send_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> !tx_ready);

  assert_tx_ready_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> $past(instr_tick));

  assert_overrun_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> $past(kb_valid && rx_ready));
endmodule

bind term_mmio term_mmio_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .kb_valid  (kb_valid),
  .rx_ready  (rx_rdy),
  .rx_data   (rx_byte_q),
  .rx_overrun(rx_overrun),
  .disp_valid(disp_valid),
  .tx_ready  (tx_rdy),
  .instr_tick(instr_tick),
  .irq_rx    (irq_rx)
);

// File: tb/tb_term_mmio.sv
module tb_term_mmio;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we, bus_re;
  logic [31:0] bus_wdata, bus_rdata;
  logic        kb_valid, instr_tick, disp_valid, irq_rx, irq_tx, rx_overrun;
  logic [7:0]  kb_byte, disp_byte;

  int n_chk = 0, n_fail = 0;
  logic       seen_dv;
  logic [7:0] seen_db;

  always #5 clk = ~clk;

  term_mmio dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .kb_valid(kb_valid), .kb_byte(kb_byte), .instr_tick(instr_tick),
    .disp_valid(disp_valid), .disp_byte(disp_byte), .irq_rx(irq_rx),
    .irq_tx(irq_tx), .rx_overrun(rx_overrun)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_re = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0; bus_addr = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    #1 seen_dv = disp_valid; seen_db = disp_byte;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic kb(input logic [7:0] b);
    kb_valid = 1'b1; kb_byte = b;
    #1 seen_dv = disp_valid;
    @(negedge clk);
    kb_valid = 1'b0;
  endtask

  task automatic tick();
    instr_tick = 1'b1;
    @(negedge clk);
    instr_tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d); eq("R1 rx ctrl after reset", d, 32'h0);
    rd(8'h08, d); eq("R1 tx ctrl after reset", d, 32'h1);
    eq("R1 irq lines", {irq_rx, irq_tx, rx_overrun}, 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    rd(8'h0C, d); eq("R2 tx data reads zero", d, 32'h0);
    rd(8'h10, d); eq("R2 offset 0x10 reads zero", d, 32'h0);
    rd(8'h09, d); eq("R2 misaligned reads zero", d, 32'h0);
  endtask

  task automatic t_rx();
    logic [31:0] d;
    kb(8'hA5);
    eq("R11 no echo on receive", {31'b0, seen_dv}, 32'h0);
    rd(8'h00, d); eq("R3 rx ready set", d, 32'h1);
    eq("R6 irq_rx low with enable off", {31'b0, irq_rx}, 32'h0);
    rd(8'h04, d); eq("R3 rx data byte", d, 32'hA5);
    rd(8'h00, d); eq("R4 read clears ready", d, 32'h0);
    wr(8'h04, 32'h33);
    rd(8'h04, d); eq("R4 data write ignored", d, 32'hA5);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); eq("R5 ien set, ready untouched, R2 upper zero", d, 32'h2);
    kb(8'h5A);
    eq("R6 irq_rx asserted", {31'b0, irq_rx}, 32'h1);
    rd(8'h04, d); eq("R3 second byte", d, 32'h5A);
    eq("R6 irq_rx drops after read", {31'b0, irq_rx}, 32'h0);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    kb(8'h01); kb(8'h02);
    eq("R10 overrun set", {31'b0, rx_overrun}, 32'h1);
    rd(8'h04, d); eq("R10 overwritten byte", d, 32'h02);
    eq("R10 overrun cleared by read", {31'b0, rx_overrun}, 32'h0);
    kb(8'h03);
    kb_valid = 1'b1; kb_byte = 8'h04; bus_re = 1'b1; bus_addr = 8'h04;
    #1 d = bus_rdata;
    @(negedge clk);
    kb_valid = 1'b0; bus_re = 1'b0; bus_addr = '0;
    eq("R10 collision returns old byte", d, 32'h03);
    eq("R10 collision no overrun", {31'b0, rx_overrun}, 32'h0);
    rd(8'h00, d); eq("R10 collision ready stays", d, 32'h1);
    rd(8'h04, d); eq("R10 collision new byte", d, 32'h04);
  endtask

  task automatic t_tx();
    logic [31:0] d;
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); eq("R5 tx ien set", d, 32'h3);
    eq("R6 irq_tx asserted", {31'b0, irq_tx}, 32'h1);
    wr(8'h0C, 32'h1C3);
    eq("R7 disp_valid pulse", {31'b0, seen_dv}, 32'h1);
    eq("R7 disp_byte", {24'b0, seen_db}, 32'hC3);
    eq("R7 disp_valid one cycle", {31'b0, disp_valid}, 32'h0);
    rd(8'h08, d); eq("R7 tx busy", d, 32'h2);
    eq("R6 irq_tx low while busy", {31'b0, irq_tx}, 32'h0);
    wr(8'h0C, 32'h77);
    eq("R9 write while busy dropped", {31'b0, seen_dv}, 32'h0);
    repeat (6) @(negedge clk);
    rd(8'h08, d); eq("R8 clocks alone do not count", d, 32'h2);
    tick(); tick(); tick();
    rd(8'h08, d); eq("R8 busy before last tick", d, 32'h2);
    tick();
    rd(8'h08, d); eq("R8 R9 ready after exact tick count", d, 32'h3);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_re = 1'b0; bus_wdata = '0;
    kb_valid = 1'b0; kb_byte = '0; instr_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_map();
    t_rx();
    t_overrun();
    t_tx();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule